// File: doc/BRIEF.md
# Shared-Select Arithmetic/Logic Unit

This block is a purely combinational n-bit arithmetic/logic unit for a register-to-register datapath. An adder forms `A + Y + carry`. The second operand `Y` is picked by a small operand-conditioning stage from four choices: zero, B, the complement of B, or all ones. This one adder therefore covers transfer, increment, add, add-with-carry, subtract, subtract-with-borrow, decrement and a second transfer code. A bitwise unit alongside it gives AND, OR, XOR and complement of A. A final two-way selector picks which of the two units drives the result.

The control is four bits wide: a mode bit, two operand-select bits and the carry input. The carry input does two jobs. It is the adder's carry in, and it is also the low select bit of the bitwise unit, while the low operand-select bit is the bitwise unit's high select bit. This shared wiring keeps the control at four bits. The block also reports carry-out, signed overflow, negative and zero flags.

Top module: `shared_alu`

## Requirements
- R1: With `mode_logic`=0, the result is `op_a + Y + carry_in` modulo 2^W. `Y` is set by `{ysel_hi,ysel_lo}`: 00 gives zero, 01 gives `op_b`, 10 gives the bitwise complement of `op_b`, and 11 gives all ones.
- R2: The control `{mode_logic,ysel_hi,ysel_lo,carry_in}` = 0101 yields `op_a - op_b` in two's complement. Code 0110 yields `op_a - 1`, and code 0111 passes `op_a` through unchanged.
- R3: With `mode_logic`=1, `{ysel_lo,carry_in}` picks the bitwise operation: 00 AND, 01 OR, 10 XOR, 11 complement of `op_a`. `ysel_hi` has no effect on the result in this mode.
- R4: In arithmetic mode, `carry_out` is the carry leaving the most significant bit of the addition.
- R5: In arithmetic mode, `overflow` is the XOR of the carry into the most significant bit and the carry out of it. For example, 0x7F + 1 at W=8 gives 1, and 0x80 - 1 gives 1.
- R6: In logic mode, `carry_out` and `overflow` are both 0.
- R7: `zero` is 1 exactly when every result bit is 0.
- R8: `negative` equals the most significant result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| mode_logic | input | 1 | 0 selects the arithmetic result, 1 selects the bitwise result |
| ysel_hi | input | 1 | High operand-select bit for the adder |
| ysel_lo | input | 1 | Low operand-select bit for the adder; high select bit of the bitwise unit |
| carry_in | input | 1 | Adder carry in; low select bit of the bitwise unit |
| result | output | W | Selected result |
| carry_out | output | 1 | Carry out of the MSB (0 in logic mode) |
| overflow | output | 1 | Signed overflow (0 in logic mode) |
| negative | output | 1 | Result MSB |
| zero | output | 1 | Result is all zeros |

## Verification
The overflow flag is the hardest case to reach, because it needs the carry into the top bit to differ from the carry out of it. Uniform random operands produce that only now and then, and rarely at the exact edges 0x7F/0x80. The stimulus therefore adds directed vectors at the signed limits for add, increment, subtract and decrement. It also includes a subtract of equal operands, which must set carry and zero together. A second hard case is proving that `ysel_hi` has no effect in logic mode. To show this, every logic-mode vector is applied twice with only that bit flipped, and the two results must match.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Adder second-operand choice, index = {ysel_hi, ysel_lo}
  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_B    = 2'b01,
    YS_NOTB = 2'b10,
    YS_ONES = 2'b11
  } ysel_e;

  // Bitwise operation, index = {ysel_lo, carry_in}
  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } lsel_e;
endpackage

// File: rtl/alu_yselect.sv
module alu_yselect
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  ysel_e        sel,
  output logic [W-1:0] y_out
);
  always_comb begin
    unique case (sel)
      YS_ZERO: y_out = '0;
      YS_B:    y_out = b_in;
      YS_NOTB: y_out = ~b_in;
      YS_ONES: y_out = '1;
      default: y_out = '0;
    endcase
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] y_in,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_top_in,
  output logic         c_top_out
);
  logic [W:0] chain;

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a_in[i] ^ y_in[i] ^ chain[i];
    assign chain[i+1] = (a_in[i] & y_in[i]) | (chain[i] & (a_in[i] ^ y_in[i]));
  end

  assign c_top_in  = chain[W-1];
  assign c_top_out = chain[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  lsel_e        sel,
  output logic [W-1:0] g_out
);
  always_comb begin
    unique case (sel)
      LG_AND:  g_out = a_in & b_in;
      LG_OR:   g_out = a_in | b_in;
      LG_XOR:  g_out = a_in ^ b_in;
      LG_NOTA: g_out = ~a_in;
      default: g_out = '0;
    endcase
  end
endmodule

// File: rtl/shared_alu.sv
module shared_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         mode_logic,
  input  logic         ysel_hi,
  input  logic         ysel_lo,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         negative,
  output logic         zero
);
  localparam int MSB = W - 1;

  ysel_e        y_sel;
  lsel_e        l_sel;
  logic [W-1:0] y_val;
  logic [W-1:0] arith_g;
  logic [W-1:0] logic_g;
  logic         c_into_msb;
  logic         c_out_msb;

  // Shared select wiring: carry_in doubles as the bitwise low select
  assign y_sel = ysel_e'({ysel_hi, ysel_lo});
  assign l_sel = lsel_e'({ysel_lo, carry_in});

  alu_yselect #(.W(W)) u_ysel (
    .b_in  (op_b),
    .sel   (y_sel),
    .y_out (y_val)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .a_in      (op_a),
    .y_in      (y_val),
    .c_in      (carry_in),
    .sum       (arith_g),
    .c_top_in  (c_into_msb),
    .c_top_out (c_out_msb)
  );

  alu_bitwise #(.W(W)) u_logic (
    .a_in  (op_a),
    .b_in  (op_b),
    .sel   (l_sel),
    .g_out (logic_g)
  );

  always_comb begin
    if (mode_logic) begin
      result    = logic_g;
      carry_out = 1'b0;
      overflow  = 1'b0;
    end else begin
      result    = arith_g;
      carry_out = c_out_msb;
      overflow  = c_into_msb ^ c_out_msb;
    end
  end

  assign negative = result[MSB];
  assign zero     = ~|result;
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         mode_logic,
  input logic         ysel_hi,
  input logic         ysel_lo,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow,
  input logic         negative,
  input logic         zero
);
  logic [3:0] ctl;
  assign ctl = {mode_logic, ysel_hi, ysel_lo, carry_in};

  always_comb begin
    if (!$isunknown({op_a, op_b, ctl, result, carry_out, overflow, negative, zero})) begin
      if (mode_logic) begin
        AST_LOGIC_FLAGS_CLEAR: assert (!carry_out && !overflow) else $error("logic-mode flags set"); // R6
      end
      if (ctl == 4'b0101) begin
        AST_SUB_RESULT: assert (result == W'(op_a - op_b)) else $error("subtract mismatch"); // R2
      end
      if (ctl[3] && ctl[1:0] == 2'b11) begin
        AST_NOT_A: assert (result == ~op_a) else $error("complement mismatch"); // R3
      end
      if (ctl == 4'b0010) begin
        AST_ADD_OVERFLOW: assert (overflow == ((op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1])))
          else $error("overflow mismatch"); // R5
      end
      AST_ZERO_FLAG: assert (zero == (result == '0)) else $error("zero flag mismatch"); // R7
      AST_NEG_MSB: assert (negative == result[W-1]) else $error("negative flag mismatch"); // R8
    end
  end
endmodule

bind shared_alu alu_checker #(.W(W)) u_chk (.*);

// File: tb/tb_shared_alu.sv
module tb_shared_alu;
  localparam int W = 8;

  logic clk;
  logic rst_n;
  logic [W-1:0] op_a, op_b, result;
  logic mode_logic, ysel_hi, ysel_lo, carry_in;
  logic carry_out, overflow, negative, zero;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W-1:0] e_res;
  logic e_c, e_v;

  shared_alu #(.W(W)) dut (
    .op_a(op_a), .op_b(op_b), .mode_logic(mode_logic), .ysel_hi(ysel_hi),
    .ysel_lo(ysel_lo), .carry_in(carry_in), .result(result),
    .carry_out(carry_out), .overflow(overflow), .negative(negative), .zero(zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model built from the requirements
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    logic [W-1:0] y;
    logic [W:0]   full;
    logic [W-1:0] low;
    logic         cm;
    if (c[3]) begin
      case (c[1:0])
        2'b00: e_res = a & b;
        2'b01: e_res = a | b;
        2'b10: e_res = a ^ b;
        default: e_res = ~a;
      endcase
      e_c = 1'b0;
      e_v = 1'b0;
    end else begin
      case (c[2:1])
        2'b00: y = '0;
        2'b01: y = b;
        2'b10: y = ~b;
        default: y = '1;
      endcase
      full  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c[0]};
      low   = {1'b0, a[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, c[0]};
      cm    = low[W-1];
      e_res = full[W-1:0];
      e_c   = full[W];
      e_v   = cm ^ full[W];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h ctl=%b)",
               tag, act, exp, op_a, op_b, {mode_logic, ysel_hi, ysel_lo, carry_in});
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    @(negedge clk);
    op_a = a; op_b = b;
    {mode_logic, ysel_hi, ysel_lo, carry_in} = c;
    #2;
    model(a, b, c);
    check(c[3] ? "R3 logic result" : (c[2:0] >= 3'b101 ? "R2 arith result" : "R1 arith result"),
          32'(result), 32'(e_res));
    check(c[3] ? "R6 carry" : "R4 carry", 32'(carry_out), 32'(e_c));
    check(c[3] ? "R6 overflow" : "R5 overflow", 32'(overflow), 32'(e_v));
    check("R7 zero", 32'(zero), 32'(e_res == '0));
    check("R8 negative", 32'(negative), 32'(e_res[W-1]));
  endtask

  // R3: ysel_hi has no effect in logic mode
  task automatic logic_pair(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s);
    logic [W-1:0] first;
    apply(a, b, {2'b10, s});
    first = result;
    apply(a, b, {2'b11, s});
    check("R3 ysel_hi ignored", 32'(result), 32'(first));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20131));
    rst_n = 1'b0;
    op_a = '0; op_b = '0;
    {mode_logic, ysel_hi, ysel_lo, carry_in} = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // Idle state: zero operands, transfer
    check("R7 idle zero", 32'(zero), 32'd1);
    check("R4 idle carry", 32'(carry_out), 32'd0);

    // Directed corners
    apply(8'h7F, 8'h01, 4'b0010);   // R5 positive overflow
    apply(8'hFF, 8'h01, 4'b0010);   // R4 carry, R7 zero
    apply(8'h7F, 8'h00, 4'b0001);   // R1 increment overflow
    apply(8'h5A, 8'h5A, 4'b0101);   // R2 equal subtract: zero and carry
    apply(8'h80, 8'h01, 4'b0101);   // R2 R5 negative overflow
    apply(8'h80, 8'h00, 4'b0110);   // R2 decrement overflow
    apply(8'h00, 8'h00, 4'b0110);   // R2 decrement wraps
    apply(8'hC3, 8'h00, 4'b0111);   // R2 transfer
    apply(8'h12, 8'h34, 4'b0100);   // R1 add complement
    apply(8'h12, 8'hFF, 4'b0011);   // R1 add with carry
    logic_pair(8'hF0, 8'h3C, 2'b00); // R3 AND
    logic_pair(8'hF0, 8'h3C, 2'b01); // R3 OR
    logic_pair(8'hF0, 8'h3C, 2'b10); // R3 XOR
    logic_pair(8'hFF, 8'h00, 2'b11); // R3 NOT A to zero, R6

    // Constrained random over all controls
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (($urandom % 8) == 0) a = {1'b0, {(W-1){1'b1}}};
      if (($urandom % 8) == 0) b = a;
      c = 4'($urandom);
      if (c[3]) logic_pair(a, b, c[1:0]);
      else apply(a, b, c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule